// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block collects fifteen interrupt sources, numbered 1 to 15, and turns them into a single 4-bit request level for a small processor. Each source has one bit in four registers that software reaches over a simple 32-bit register bus: an enable mask, a pending register, a write-only force register and a write-only clear register. Bit 0 of every register is reserved. A rising edge on a source input latches its pending bit.

The source number has three roles at once. It is the register bit index, the priority (a higher number wins), and the low nibble of the trap type that goes with the request. The processor reports the level it has taken on an acknowledge port, and that pending bit then drops without a software write.

Sources are assigned as follows: 1 is the correctable memory error, 2 and 3 are the serial ports, 4 to 7 are external lines, 8 and 9 are timers, and 10 to 15 are spare. The controller treats every source the same way.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset the mask register reads 0, the pending register reads 0 and `irq_level` is 0.
- R2: A write to byte offset 0x90 loads the mask from data bits 15:1. A mask bit at 1 enables its source. Reading 0x90 returns the mask, with bit 0 and bits 31:16 at 0.
- R3: A 0-to-1 change on `src_in[n]` (n = 1..15) sets pending bit n one clock later. A source held high does not set pending again once it has been cleared.
- R4: Writing offset 0x98 sets pending bit n for every data bit n (1..15) that is 1. Zero bits leave pending unchanged.
- R5: Writing offset 0x9C clears pending bit n for every data bit n that is 1. Zero bits leave pending unchanged. Reading 0x94 returns the pending register.
- R6: When an edge capture, or a force, of bit n meets a clear of bit n in the same cycle (from a clear write or an acknowledge), the pending bit ends up set.
- R7: `irq_level` equals the highest n for which pending bit n and mask bit n are both 1, or 0 when there is no such n. It follows the registers with no extra delay.
- R8: With `ack_valid` high and `ack_level` = n (1..15), pending bit n clears on the next edge. An acknowledge of level 0 changes nothing.
- R9: Reading the force offset, the clear offset or any unmapped offset returns 0.
- R10: `trap_type` equals 0x10 + `irq_level` while `irq_level` is non-zero, and is 0 otherwise.
- R11: Bit 0 is inert. `src_in[0]`, force bit 0 and mask bit 0 never make pending bit 0 or mask bit 0 read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_in | input | 16 | Source inputs, bit n is source n, bit 0 is ignored |
| ack_valid | input | 1 | Processor has taken the level on `ack_level` |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest pending, enabled source, or 0 |
| trap_type | output | 8 | Trap type that goes with `irq_level` |

## Verification
The checker watches several rules on every cycle. It confirms that no enabled pending bit sits above the reported level and that the reported level is itself pending and enabled. It also confirms that bit 0 stays clear, that forced bits and captured edges are set on the following cycle, and that an acknowledged bit drops unless a set arrives with it. Other behaviour is shown only by the bench's scenarios: the read-back values, the fact that zero bits in force or clear writes change nothing, the absence of re-capture on a held level, and the sweep of priority resolution over many mask and pending patterns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_SRC   = 15;
    localparam int TRAP_W    = 8;
    localparam logic [TRAP_W-1:0] TRAP_BASE = 8'h10;

    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_FORCE = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 8'h9C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_PEND,
        SEL_FORCE,
        SEL_CLEAR
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
    } bus_op_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MASK:  return SEL_MASK;
            OFS_PEND:  return SEL_PEND;
            OFS_FORCE: return SEL_FORCE;
            OFS_CLEAR: return SEL_CLEAR;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
    parameter int N = irqc_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N:0]   src_in,
    output logic [N:0]   rise
);
    logic [N:0] prev_q;

    assign rise[0] = 1'b0;

    for (genvar i = 1; i <= N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= src_in[i];
        end
        assign rise[i] = src_in[i] & ~prev_q[i];
    end

    always_ff @(posedge clk) prev_q[0] <= 1'b0;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int LW = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N:0]        rise,
    input  logic              ack_valid,
    input  logic [LW-1:0]     ack_level,
    output logic [N:0]        mask_q,
    output logic [N:0]        pend_q
);
    localparam logic [N:0] VALID = {{N{1'b1}}, 1'b0};

    bus_op_t    op;
    logic [N:0] wvec;
    logic [N:0] force_v;
    logic [N:0] clear_v;
    logic [N:0] ack_v;
    logic [N:0] set_v;
    logic [N:0] pend_d;

    assign op.sel = decode_ofs(bus_addr);
    assign op.wr  = bus_we;
    assign wvec   = bus_wdata[N:0] & VALID;

    assign force_v = (op.wr && op.sel == SEL_FORCE) ? wvec : '0;
    assign clear_v = (op.wr && op.sel == SEL_CLEAR) ? wvec : '0;

    for (genvar i = 0; i <= N; i++) begin : g_ack
        if (i == 0) begin : g_zero
            assign ack_v[i] = 1'b0;
        end else begin : g_lvl
            assign ack_v[i] = ack_valid && (ack_level == LW'(i));
        end
    end

    // Sets win over every kind of clear in the same cycle.
    assign set_v  = (force_v | rise) & VALID;
    assign pend_d = ((pend_q & ~clear_v & ~ack_v) | set_v) & VALID;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (op.wr && op.sel == SEL_MASK) mask_q <= wvec;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (op.sel)
            SEL_MASK: bus_rdata[N:0] = mask_q;
            SEL_PEND: bus_rdata[N:0] = pend_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
    import irqc_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int LW = $clog2(N + 1)
) (
    input  logic [N:0]        pend_q,
    input  logic [N:0]        mask_q,
    output logic [LW-1:0]     level,
    output logic [TRAP_W-1:0] trap
);
    logic [N:0] live;

    assign live = pend_q & mask_q;

    always_comb begin
        level = '0;
        for (int i = 1; i <= N; i++) begin
            if (live[i]) level = LW'(i);
        end
    end

    assign trap = (level == '0) ? '0 : (TRAP_BASE + TRAP_W'(level));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int LW = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N:0]        src_in,
    input  logic              ack_valid,
    input  logic [LW-1:0]     ack_level,
    output logic [LW-1:0]     irq_level,
    output logic [TRAP_W-1:0] trap_type
);
    logic [N:0] rise;
    logic [N:0] mask_q;
    logic [N:0] pend_q;

    irqc_edge_detect #(.N(N)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .rise   (rise)
    );

    irqc_regs #(.N(N), .LW(LW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rise      (rise),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .mask_q    (mask_q),
        .pend_q    (pend_q)
    );

    irqc_prio_enc #(.N(N), .LW(LW)) u_enc (
        .pend_q (pend_q),
        .mask_q (mask_q),
        .level  (irq_level),
        .trap   (trap_type)
    );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int LW = $clog2(N + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              ack_valid,
    input logic [LW-1:0]     ack_level,
    input logic [LW-1:0]     irq_level,
    input logic [N:0]        rise,
    input logic [N:0]        mask_q,
    input logic [N:0]        pend_q
);
    logic [N:0] live;
    logic       fwr;
    assign live = pend_q & mask_q;
    assign fwr  = bus_we && (bus_addr == OFS_FORCE);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (pend_q == '0 && mask_q == '0));

    // R7
    a_r7_level_live: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> live[irq_level]);

    a_r7_none_above: assert property (@(posedge clk) disable iff (rst)
        ((live & ~{{N{1'b0}}, 1'b1}) >> irq_level) <= 1);

    // R11
    a_r11_bit0_inert: assert property (@(posedge clk) disable iff (rst)
        (pend_q[0] == 1'b0 && mask_q[0] == 1'b0));

    // R4 and R6
    a_r4_force_sets: assert property (@(posedge clk) disable iff (rst)
        fwr |=> ((pend_q & $past(bus_wdata[N:0]) & ~{{N{1'b0}}, 1'b1})
                 == ($past(bus_wdata[N:0]) & ~{{N{1'b0}}, 1'b1})));

    // R3 and R6
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R8
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_level != '0 && !rise[ack_level] &&
         !(fwr && bus_wdata[ack_level]))
        |=> !pend_q[$past(ack_level)]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N), .LW(LW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .irq_level (irq_level),
    .rise      (rise),
    .mask_q    (mask_q),
    .pend_q    (pend_q)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] src_in = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic [3:0]  irq_level;
    logic [7:0]  trap_type;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .ack_valid(ack_valid), .ack_level(ack_level),
        .irq_level(irq_level), .trap_type(trap_type)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [3:0] top_of(input logic [15:0] v);
        logic [3:0] r = 0;
        for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
        return r;
    endfunction

    initial begin
        logic [31:0] d;
        logic [15:0] p, m;
        logic [31:0] seed;
        @(negedge clk); step(); step();
        rst = 1'b0;
        // R1
        rd(8'h90, d); chk("R1 mask", d, 0);
        rd(8'h94, d); chk("R1 pend", d, 0);
        chk("R1 level", {28'b0, irq_level}, 0);

        // R2 and R11: mask write/read
        wr(8'h90, 32'hFFFF_FFFF);
        rd(8'h90, d); chk("R2 R11 mask all", d, 32'h0000_FFFE);
        wr(8'h90, 32'h0000_A5A5);
        rd(8'h90, d); chk("R2 mask pattern", d, 32'h0000_A5A4);

        // R9: reads of write-only and unmapped offsets
        rd(8'h98, d); chk("R9 force reads 0", d, 0);
        rd(8'h9C, d); chk("R9 clear reads 0", d, 0);
        rd(8'h40, d); chk("R9 unmapped", d, 0);

        // R3 per source, and R11 via src_in[0]
        wr(8'h90, 32'h0);
        for (int n = 0; n < 16; n++) begin
            src_in = 16'(1 << n);
            step();
            rd(8'h94, d);
            chk(n == 0 ? "R11 src0 inert" : "R3 edge sets", d, n == 0 ? 0 : (1 << n));
            step();
            wr(8'h9C, 32'hFFFF);
            rd(8'h94, d);
            chk("R3 held level no recapture", d, 0);
            src_in = 0;
            step();
        end

        // R4 and R5 zero bits
        wr(8'h98, 32'h0000_0301);
        rd(8'h94, d); chk("R4 R11 force", d, 32'h0300);
        wr(8'h98, 32'h0000_0010);
        rd(8'h94, d); chk("R4 zeros keep", d, 32'h0310);
        wr(8'h9C, 32'h0000_0100);
        rd(8'h94, d); chk("R5 clear one", d, 32'h0210);
        wr(8'h9C, 32'h0);
        rd(8'h94, d); chk("R5 zeros keep", d, 32'h0210);
        wr(8'h9C, 32'hFFFF);

        // R6: capture and clear same cycle
        bus_addr = 8'h9C; bus_wdata = 32'h40; bus_we = 1'b1; src_in = 16'h0040;
        step();
        bus_we = 1'b0;
        rd(8'h94, d); chk("R6 capture beats clear", d, 32'h40);
        src_in = 0;
        wr(8'h9C, 32'hFFFF);

        // R8: acknowledge ordering
        wr(8'h90, 32'hFFFF);
        wr(8'h98, 32'h8420);
        chk("R7 level15", {28'b0, irq_level}, 15);
        chk("R10 trap", {24'b0, trap_type}, 32'h1F);
        ack_valid = 1'b1; ack_level = 15; step();
        chk("R8 ack15", {28'b0, irq_level}, 10);
        ack_level = 10; step();
        chk("R8 ack10", {28'b0, irq_level}, 5);
        ack_level = 0; step();
        chk("R8 ack0 no effect", {28'b0, irq_level}, 5);
        rd(8'h94, d); chk("R8 pend after ack0", d, 32'h20);
        ack_level = 5; src_in = 16'h0020; step();
        ack_valid = 1'b0; src_in = 0;
        rd(8'h94, d); chk("R6 capture beats ack", d, 32'h20);
        ack_valid = 1'b1; ack_level = 5; step(); ack_valid = 1'b0;
        chk("R7 R10 idle", {20'b0, irq_level, trap_type}, 0);

        // R7/R10 sweep
        seed = 32'h1234_5678;
        for (int k = 0; k < 200; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            p = seed[15:0]; m = seed[31:16];
            if (k < 16) begin p = 16'hFFFF; m = 16'(1 << k); end
            wr(8'h9C, 32'hFFFF);
            wr(8'h98, {16'b0, p});
            wr(8'h90, {16'b0, m});
            chk("R7 sweep level", {28'b0, irq_level}, {28'b0, top_of(p & m)});
            chk("R10 sweep trap", {24'b0, trap_type},
                top_of(p & m) == 0 ? 0 : 32'h10 + top_of(p & m));
        end

        // R1 again after a reset in mid-run
        rst = 1'b1; step(); rst = 1'b0;
        rd(8'h90, d); chk("R1 re-reset mask", d, 0);
        rd(8'h94, d); chk("R1 re-reset pend", d, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule